// File: doc/BRIEF.md
# Bus Idle-Gap Break Requester

This block lets a slave on a shared open-drain data line ask the bus master for attention without colliding with traffic. It watches the synchronized line on a periodic timing tick, nominally one tick every 0.5 ms. It looks for a quiet window: first a long low stretch, then a long high stretch. When that window is found and the slave has a break request pending, the block pulls the line low for a fixed number of ticks and then lets it go. Any bit clocked in by the bus receiver means the bus is busy, so the block abandons whatever it was doing and starts looking again.

The block is a three-state machine with one shared tick counter. The counter saturates at 16 and never wraps.

- **S_LOW_SEEK** (reset state) counts consecutive low ticks.
  - Transition *low_done*: the count reaches `LOW_TICKS` (10), and the machine moves to S_HIGH_SEEK.
  - Transition *low_broken*: a high sample clears the count, and the machine stays in S_LOW_SEEK.
- **S_HIGH_SEEK** counts consecutive high ticks.
  - Transition *high_wait*: a low sample arrives before any high sample of this phase. The machine stays in S_HIGH_SEEK with the count at zero.
  - Transition *high_broken*: a low sample arrives after at least one high sample. The machine returns to S_LOW_SEEK.
  - Transition *gap_found*: the count reaches `HIGH_TICKS` (4). The machine goes to S_BREAK when a break is requested, and to S_LOW_SEEK otherwise.
- **S_BREAK** drives the line low.
  - Transition *break_done*: after `BREAK_TICKS` (8) ticks, the machine returns to S_LOW_SEEK.
- Transition *abort*: from any state, a received-bit pulse forces S_LOW_SEEK with the count at zero.

Top module: `idle_gap_breaker`

## Requirements
- R1: After a synchronous reset, `drive_low` and `break_active` are 0, the machine is in S_LOW_SEEK, and the synchronizer flops hold 1, which is the idle bus level.
- R2: The low phase completes only on the 10th consecutive tick whose synchronized line sample is 0. A tick that samples 1 during the low phase clears the low count.
- R3: In the high phase, the 4th consecutive tick that samples 1 completes the gap. If `break_req` is 1 on that tick, `drive_low` and `break_active` become 1 from the clock edge of that tick.
- R4: In the high phase, a tick that samples 0 before any tick of the phase has sampled 1 keeps the machine in the high phase with its count at zero. No new low phase is needed.
- R5: In the high phase, a tick that samples 0 after one or more ticks that sampled 1 returns the machine to the low phase. A further 10 low ticks are then needed.
- R6: If `break_req` is 0 on the tick that completes the gap, the line is not driven and the machine returns to the low phase.
- R7: A break keeps `drive_low` at 1 for exactly 8 ticks. It drops on the clock edge of the 8th tick counted after the break began. Line samples taken during the break have no effect.
- R8: A `bit_rx` pulse returns the machine to S_LOW_SEEK with the count at zero on that clock edge, from any state. This releases the line if a break is in progress. It takes priority over a tick in the same cycle.
- R9: `line_in` passes through a 2-flop synchronizer, so a tick uses the value that `line_in` had two clocks before it.
- R10: In a cycle with neither `tick` nor `bit_rx`, the state and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle timing pulse, one per 0.5 ms |
| line_in | input | 1 | Raw sampled level of the shared data line |
| break_req | input | 1 | 1 when the slave wants to issue a break |
| bit_rx | input | 1 | Pulse from the bus receiver: a bit was clocked in |
| drive_low | output | 1 | Enable for the external open-drain pull-down |
| break_active | output | 1 | 1 while a break is being driven |

## Verification
The bench runs the following edge cases against a behavioural reference that is compared on every clock:

- **Gap counted one tick early or late.** Low runs of 9 and 10 ticks, and high runs of 3 and 4 ticks, separate a design that miscounts; such a design would break in a window that is too short or miss the window.
- **Both high-phase restarts handled the same way.** Low ticks before and after the first high tick tell R4 from R5. A design that treats both alike would either refuse a legitimate gap or break after a line that was not quiet.
- **Wrong break length or stuck pull-down.** The break is timed tick by tick. A `bit_rx` pulse lands in the middle of a break and in the same cycle as a tick; a design that fails here would pull the line low too long, or leave it held low while the bus is active.
- **Synchronizer missing.** A line change one clock before a tick exposes a design without the two-flop synchronizer, because it would act on the new level too soon.

// File: rtl/igb_pkg.sv
package igb_pkg;
    typedef enum logic [1:0] {
        S_LOW_SEEK  = 2'd0,
        S_HIGH_SEEK = 2'd1,
        S_BREAK     = 2'd2
    } igb_state_t;
endpackage

// File: rtl/igb_sync.sv
module igb_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/igb_fsm.sv
module igb_fsm
    import igb_pkg::*;
#(
    parameter int LOW_TICKS   = 10,
    parameter int HIGH_TICKS  = 4,
    parameter int BREAK_TICKS = 8,
    parameter int CNT_SAT     = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line_s,
    input  logic break_req,
    input  logic bit_rx,
    output logic drive_low,
    output logic break_active
);
    localparam int CW = $clog2(CNT_SAT + 1);
    localparam logic [CW-1:0] LOW_N   = CW'(LOW_TICKS);
    localparam logic [CW-1:0] HIGH_N  = CW'(HIGH_TICKS);
    localparam logic [CW-1:0] BREAK_N = CW'(BREAK_TICKS);
    localparam logic [CW-1:0] SAT_N   = CW'(CNT_SAT);

    igb_state_t st, st_n;
    logic [CW-1:0] cnt, cnt_n, cnt_inc;

    assign cnt_inc = (cnt == SAT_N) ? cnt : cnt + 1'b1;

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (bit_rx) begin
            st_n  = S_LOW_SEEK;
            cnt_n = '0;
        end else if (tick) begin
            unique case (st)
                S_LOW_SEEK: begin
                    if (line_s) begin
                        cnt_n = '0;
                    end else if (cnt_inc == LOW_N) begin
                        st_n  = S_HIGH_SEEK;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
                S_HIGH_SEEK: begin
                    if (line_s) begin
                        if (cnt_inc == HIGH_N) begin
                            st_n  = break_req ? S_BREAK : S_LOW_SEEK;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt_inc;
                        end
                    end else if (cnt != '0) begin
                        st_n  = S_LOW_SEEK;
                        cnt_n = '0;
                    end
                end
                S_BREAK: begin
                    if (cnt_inc == BREAK_N) begin
                        st_n  = S_LOW_SEEK;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
                default: begin
                    st_n  = S_LOW_SEEK;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_LOW_SEEK;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        drive_low    = 1'b0;
        break_active = 1'b0;
        unique case (st)
            S_BREAK: begin
                drive_low    = 1'b1;
                break_active = 1'b1;
            end
            default: begin
                drive_low    = 1'b0;
                break_active = 1'b0;
            end
        endcase
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (st == S_LOW_SEEK) && !drive_low);

    assert_high_clears_low_R2: assert property (@(posedge clk) disable iff (rst)
        (st == S_LOW_SEEK && tick && line_s && !bit_rx) |=> (cnt == '0));

    assert_break_after_gap_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_low) |-> ($past(tick) && $past(line_s) && $past(break_req)
                              && $past(st) == S_HIGH_SEEK));

    assert_release_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(drive_low) |-> ($past(tick) || $past(bit_rx)));

    assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
        bit_rx |=> (st == S_LOW_SEEK) && (cnt == '0) && !drive_low);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!tick && !bit_rx) |=> ($stable(st) && $stable(cnt)));

    assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= SAT_N);
endmodule

// File: rtl/idle_gap_breaker.sv
module idle_gap_breaker #(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_TICKS   = 10,
    parameter int HIGH_TICKS  = 4,
    parameter int BREAK_TICKS = 8,
    parameter int CNT_SAT     = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line_in,
    input  logic break_req,
    input  logic bit_rx,
    output logic drive_low,
    output logic break_active
);
    logic line_s;

    igb_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_in),
        .q   (line_s)
    );

    igb_fsm #(
        .LOW_TICKS   (LOW_TICKS),
        .HIGH_TICKS  (HIGH_TICKS),
        .BREAK_TICKS (BREAK_TICKS),
        .CNT_SAT     (CNT_SAT)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .line_s       (line_s),
        .break_req    (break_req),
        .bit_rx       (bit_rx),
        .drive_low    (drive_low),
        .break_active (break_active)
    );
endmodule

// File: tb/idle_gap_breaker_bench.sv
module idle_gap_breaker_bench;
    localparam int TP = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic line_in = 1'b1;
    logic break_req = 1'b0;
    logic bit_rx = 1'b0;
    logic drive_low, break_active;

    int tests = 0;
    int fails = 0;
    string tag = "R1";

    idle_gap_breaker u_idle_gap_breaker (
        .clk(clk), .rst(rst), .tick(tick), .line_in(line_in),
        .break_req(break_req), .bit_rx(bit_rx),
        .drive_low(drive_low), .break_active(break_active)
    );

    always #4 clk = ~clk;

    // behavioural reference: 0 = seeking low, 1 = seeking high, 2 = breaking
    int m_phase = 0;
    int m_count = 0;
    bit m_hist[$] = '{1'b1, 1'b1};

    always @(posedge clk) begin
        bit seen;
        seen = m_hist[1];
        if (rst) begin
            m_phase = 0; m_count = 0;
            m_hist = '{1'b1, 1'b1};
        end else begin
            if (bit_rx) begin
                m_phase = 0; m_count = 0;
            end else if (tick) begin
                if (m_phase == 0) begin
                    if (seen) m_count = 0;
                    else begin
                        m_count++;
                        if (m_count >= 10) begin m_phase = 1; m_count = 0; end
                    end
                end else if (m_phase == 1) begin
                    if (seen) begin
                        m_count++;
                        if (m_count >= 4) begin
                            m_phase = break_req ? 2 : 0;
                            m_count = 0;
                        end
                    end else if (m_count > 0) begin
                        m_phase = 0; m_count = 0;
                    end
                end else begin
                    m_count++;
                    if (m_count >= 8) begin m_phase = 0; m_count = 0; end
                end
            end
            m_hist.pop_back();
            m_hist.push_front(line_in);
        end
    end

    task automatic check(string t, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", t, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(tag, drive_low, m_phase == 2);
            check(tag, break_active, m_phase == 2);
        end
    end

    task automatic ticks(int n, logic v);
        for (int i = 0; i < n; i++) begin
            line_in = v;
            repeat (TP - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic pulse_rx(logic with_tick);
        bit_rx = 1'b1; tick = with_tick;
        @(negedge clk);
        bit_rx = 1'b0; tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        check("R1 drive", drive_low, 1'b0);
        check("R1 active", break_active, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", drive_low, 1'b0);

        // R3 full gap with request
        tag = "R3"; break_req = 1'b1;
        ticks(10, 1'b0); ticks(3, 1'b1);
        check("R3 not before 4th high", drive_low, 1'b0);
        ticks(1, 1'b1);
        check("R3 break starts", drive_low, 1'b1);
        tag = "R7";
        ticks(7, 1'b0);
        check("R7 held 7 ticks", drive_low, 1'b1);
        repeat (5) @(negedge clk);
        check("R10 no tick no change", drive_low, 1'b1);
        ticks(1, 1'b1);
        check("R7 released after 8", drive_low, 1'b0);

        // R2 high sample clears low count
        tag = "R2";
        ticks(5, 1'b0); ticks(1, 1'b1); ticks(9, 1'b0); ticks(4, 1'b1);
        check("R2 9 lows insufficient", drive_low, 1'b0);
        ticks(10, 1'b0); ticks(4, 1'b1);
        check("R2 10 lows sufficient", drive_low, 1'b1);
        ticks(8, 1'b1);
        check("R7 end", drive_low, 1'b0);

        // R6 no request
        tag = "R6"; break_req = 1'b0;
        ticks(10, 1'b0); ticks(4, 1'b1);
        check("R6 no break without request", drive_low, 1'b0);
        break_req = 1'b1;
        ticks(4, 1'b1);
        check("R6 back to low seek", drive_low, 1'b0);

        // R4 extra lows keep high phase waiting
        tag = "R4";
        ticks(10, 1'b0); ticks(3, 1'b0); ticks(4, 1'b1);
        check("R4 wait then gap", drive_low, 1'b1);
        ticks(8, 1'b1);

        // R5 low after a high restarts
        tag = "R5";
        ticks(10, 1'b0); ticks(2, 1'b1); ticks(1, 1'b0); ticks(4, 1'b1);
        check("R5 restart low phase", drive_low, 1'b0);
        ticks(9, 1'b0); ticks(4, 1'b1);
        check("R5 9 lows after restart", drive_low, 1'b0);

        // R8 abort in low phase, mid-break, and together with a tick
        tag = "R8";
        ticks(6, 1'b0); pulse_rx(1'b0); ticks(4, 1'b0); ticks(4, 1'b1);
        check("R8 abort low phase", drive_low, 1'b0);
        ticks(10, 1'b0); ticks(4, 1'b1);
        check("R8 break begun", drive_low, 1'b1);
        ticks(3, 1'b1); pulse_rx(1'b0);
        check("R8 abort releases line", drive_low, 1'b0);
        ticks(10, 1'b0); ticks(3, 1'b1);
        line_in = 1'b1; repeat (TP - 1) @(negedge clk);
        pulse_rx(1'b1);
        check("R8 priority over tick", drive_low, 1'b0);

        // R9 late line change is not seen yet
        tag = "R9";
        ticks(9, 1'b0);
        repeat (TP - 1) @(negedge clk);
        line_in = 1'b1; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        ticks(4, 1'b1);
        check("R9 synchronizer delay", drive_low, 1'b1);
        ticks(8, 1'b1);
        check("R9 break ends", drive_low, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule